// File: doc/BRIEF.md
# Load/Store Multiple Address Sequencer

This block turns one block-transfer request into a stream of per-register beats. A request carries a base byte address, a 16-bit bitmap that selects which of 16 general-purpose registers are moved, a 2-bit addressing order and a writeback enable. The block counts the selected registers in the cycle after the request is taken. It then issues one beat per cycle. Each beat carries the register index and the word address that a memory stage should read or write.

The selected registers always fill a contiguous run of word addresses. The lowest-numbered register sits at the lowest address. The addressing order sets where that run lies relative to the base. It can lie above or below the base, and the base can be stepped before the first access or after it. When the run ends, the block pulses a completion strobe. If writeback was requested, the updated base comes out with that strobe. Memory access, data movement and faults in the middle of a transfer belong to the surrounding pipeline.

Top module: `lsm_addr_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no request, busy_o, beat_valid_o, done_o and wb_valid_o are all 0.
- R2: A start_i pulse seen at a clock edge while busy_o is 0 is taken, and busy_o is 1 in the following cycle. start_i seen while busy_o is 1 is ignored: the sequence in flight keeps its beats, addresses and writeback.
- R3: For a taken request, beats appear on consecutive cycles starting two cycles after the start edge. There is one beat for each set bit of reg_list_i. beat_reg_o gives the bit positions in strictly ascending order.
- R4: Within a sequence, each beat address is the previous one plus 4, modulo 2^32.
- R5: The first beat address depends on mode_i: 2'b00 (increment, step after) gives base. 2'b01 (increment, step before) gives base+4. 2'b10 (decrement, step after) gives base-4n+4. 2'b11 (decrement, step before) gives base-4n. Here n is the number of set bits.
- R6: done_o is 1 for exactly one cycle, the cycle after the last beat, and never in the same cycle as a beat.
- R7: wb_valid_o equals wb_en_i of the request during the done_o cycle and is 0 otherwise. wb_addr_o is then base+4n when mode_i bit 1 is 0, and base-4n when it is 1.
- R8: An all-zero reg_list_i issues no beat, and done_o rises two cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when idle |
| base_i | input | 32 | Base byte address |
| reg_list_i | input | 16 | Bitmap of registers to transfer |
| mode_i | input | 2 | Addressing order: bit 1 decrement, bit 0 step before |
| wb_en_i | input | 1 | Request the final base value |
| busy_o | output | 1 | Request in progress, including the done cycle |
| beat_valid_o | output | 1 | Beat strobe |
| beat_reg_o | output | 4 | Register index of the current beat |
| beat_addr_o | output | 32 | Word address of the current beat |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Final base value is valid |
| wb_addr_o | output | 32 | Final base value |

## Verification
A corrupted remaining-register mask shows up at the ports as a wrong beat count, a repeated index or an index out of order, visible on the very beat that follows the corruption. A wrong starting address or step is exposed on the first beat or on the next beat pair. A mis-sized population count or a wrong state change moves done_o or the writeback value, so it is caught one cycle after the expected last beat at the latest. The empty-list path, the wrap of addresses below zero and a request poked in mid-sequence are driven on purpose, because random lists rarely hit them.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'b00,
    AM_INC_BEFORE = 2'b01,
    AM_DEC_AFTER  = 2'b10,
    AM_DEC_BEFORE = 2'b11
  } am_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALC,
    ST_RUN,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/lsm_lowest.sv
module lsm_lowest #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  // Scan downward so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan
  import lsm_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned CW   = 5,
  parameter int unsigned STEP = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  am_e           mode_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] final_o
);
  logic [AW-1:0] span;

  always_comb begin
    span = AW'(cnt_i) * AW'(STEP);
    unique case (mode_i)
      AM_INC_AFTER:  first_o = base_i;
      AM_INC_BEFORE: first_o = base_i + AW'(STEP);
      AM_DEC_AFTER:  first_o = base_i - span + AW'(STEP);
      default:       first_o = base_i - span;
    endcase
    final_o = mode_i[1] ? base_i - span : base_i + span;
  end
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 16,
  parameter int unsigned STEP = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [AW-1:0]           base_i,
  input  logic [NREG-1:0]         reg_list_i,
  input  logic [1:0]              mode_i,
  input  logic                    wb_en_i,
  output logic                    busy_o,
  output logic                    beat_valid_o,
  output logic [$clog2(NREG)-1:0] beat_reg_o,
  output logic [AW-1:0]           beat_addr_o,
  output logic                    done_o,
  output logic                    wb_valid_o,
  output logic [AW-1:0]           wb_addr_o
);
  localparam int unsigned IW = $clog2(NREG);
  localparam int unsigned CW = $clog2(NREG + 1);

  seq_st_e       st_q;
  logic [NREG-1:0] mask_q;
  logic [AW-1:0] base_q, addr_q, wb_addr_q;
  am_e           mode_q;
  logic          wb_en_q;

  logic [CW-1:0] cnt;
  logic [AW-1:0] first_addr, final_addr;
  logic [IW-1:0] low_idx;
  logic          last_beat;

  lsm_popcnt #(.W(NREG), .CW(CW)) u_popcnt (
    .vec_i (mask_q),
    .cnt_o (cnt)
  );

  lsm_lowest #(.W(NREG), .IW(IW)) u_lowest (
    .vec_i (mask_q),
    .idx_o (low_idx)
  );

  lsm_addr_plan #(.AW(AW), .CW(CW), .STEP(STEP)) u_plan (
    .base_i  (base_q),
    .cnt_i   (cnt),
    .mode_i  (mode_q),
    .first_o (first_addr),
    .final_o (final_addr)
  );

  assign last_beat = (mask_q & (mask_q - NREG'(1))) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      mask_q    <= '0;
      base_q    <= '0;
      addr_q    <= '0;
      wb_addr_q <= '0;
      mode_q    <= AM_INC_AFTER;
      wb_en_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          mask_q  <= reg_list_i;
          base_q  <= base_i;
          mode_q  <= am_e'(mode_i);
          wb_en_q <= wb_en_i;
          st_q    <= ST_CALC;
        end
        ST_CALC: begin
          addr_q    <= first_addr;
          wb_addr_q <= final_addr;
          st_q      <= (cnt == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          mask_q <= mask_q & (mask_q - NREG'(1));
          addr_q <= addr_q + AW'(STEP);
          if (last_beat) st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = st_q != ST_IDLE;
  assign beat_valid_o = st_q == ST_RUN;
  assign beat_reg_o   = low_idx;
  assign beat_addr_o  = addr_q;
  assign done_o       = st_q == ST_DONE;
  assign wb_valid_o   = done_o & wb_en_q;
  assign wb_addr_o    = wb_addr_q;
endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 16,
  parameter int unsigned STEP = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic [AW-1:0]           base_i,
  input logic [NREG-1:0]         reg_list_i,
  input logic [1:0]              mode_i,
  input logic                    wb_en_i,
  input logic                    busy_o,
  input logic                    beat_valid_o,
  input logic [$clog2(NREG)-1:0] beat_reg_o,
  input logic [AW-1:0]           beat_addr_o,
  input logic                    done_o,
  input logic                    wb_valid_o,
  input logic [AW-1:0]           wb_addr_o
);
  assert_take_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  assert_beat_in_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> busy_o);

  assert_reg_ascend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && $past(beat_valid_o) |-> beat_reg_o > $past(beat_reg_o));

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && $past(beat_valid_o) |-> beat_addr_o == $past(beat_addr_o) + AW'(STEP));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_no_beat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !beat_valid_o);

  assert_wb_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o);
endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.AW(AW), .NREG(NREG), .STEP(STEP)) u_chk (.*);

// File: tb/lsm_addr_seq_tb_top.sv
`timescale 1ns / 1ps
module lsm_addr_seq_tb_top;
  localparam real CLK_NS = 8.0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] reg_list_i = '0;
  logic [1:0]  mode_i = '0;
  logic        wb_en_i = 1'b0;
  logic        busy_o, beat_valid_o, done_o, wb_valid_o;
  logic [3:0]  beat_reg_o;
  logic [31:0] beat_addr_o, wb_addr_o;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #(CLK_NS / 2) clk_i = ~clk_i;

  lsm_addr_seq dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] l);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(l[i]);
    return n;
  endfunction

  function automatic logic [31:0] first_exp(input logic [31:0] b, input logic [15:0] l, input logic [1:0] m);
    logic [31:0] span = 32'(popc(l)) * 32'd4;
    case (m)
      2'b00:   return b;
      2'b01:   return b + 32'd4;
      2'b10:   return b - span + 32'd4;
      default: return b - span;
    endcase
  endfunction

  function automatic logic [31:0] final_exp(input logic [31:0] b, input logic [15:0] l, input logic [1:0] m);
    logic [31:0] span = 32'(popc(l)) * 32'd4;
    return m[1] ? b - span : b + span;
  endfunction

  // poke: fire a second start with other inputs in the cycle after start
  task automatic run_op(input logic [31:0] b, input logic [15:0] l, input logic [1:0] m,
                        input bit wb, input bit poke);
    int n, k, cyc, nxt;
    logic [31:0] fa;
    bit fin;
    n = popc(l);
    fa = first_exp(b, l, m);
    @(negedge clk_i);
    start_i = 1; base_i = b; reg_list_i = l; mode_i = m; wb_en_i = wb;
    @(posedge clk_i);
    @(negedge clk_i);
    cyc = 1;
    chk(busy_o == 1'b1, "R2 busy after start", 32'(busy_o), 32'd1);
    if (poke) begin
      base_i = ~b; reg_list_i = ~l; mode_i = ~m; wb_en_i = ~wb;
    end else start_i = 0;
    k = 0; nxt = 0; fin = 0;
    while (!fin && cyc < 40) begin
      @(posedge clk_i);
      @(negedge clk_i);
      cyc++;
      start_i = 0;
      if (beat_valid_o) begin
        while (nxt < 16 && !l[nxt]) nxt++;
        chk(cyc == 2 + k, "R3 beat cycle", 32'(cyc), 32'(2 + k));
        chk(beat_reg_o == 4'(nxt), "R3 beat register", 32'(beat_reg_o), 32'(nxt));
        if (k == 0)
          chk(beat_addr_o == fa, "R5 first address", beat_addr_o, fa);
        else
          chk(beat_addr_o == fa + 32'(4 * k), "R4 address step", beat_addr_o, fa + 32'(4 * k));
        chk(!done_o, "R6 done with beat", 32'(done_o), 32'd0);
        k++; nxt++;
      end
      if (done_o) begin
        fin = 1;
        chk(cyc == 2 + n, n == 0 ? "R8 empty done cycle" : "R6 done cycle", 32'(cyc), 32'(2 + n));
        chk(wb_valid_o == wb, "R7 wb valid", 32'(wb_valid_o), 32'(wb));
        if (wb) chk(wb_addr_o == final_exp(b, l, m), "R7 wb address", wb_addr_o, final_exp(b, l, m));
      end else begin
        chk(!wb_valid_o, "R7 wb outside done", 32'(wb_valid_o), 32'd0);
      end
    end
    chk(fin, "R6 done seen", 32'(fin), 32'd1);
    chk(k == n, n == 0 ? "R8 no beats" : "R3 beat count", 32'(k), 32'(n));
    if (poke) chk(1'b1, "R2 poke ignored", 32'd0, 32'd0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R6 done single cycle", {30'd0, done_o, busy_o}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(!busy_o && !beat_valid_o && !done_o && !wb_valid_o, "R1 in reset",
        {28'd0, busy_o, beat_valid_o, done_o, wb_valid_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !beat_valid_o && !done_o && !wb_valid_o, "R1 idle after reset",
        {28'd0, busy_o, beat_valid_o, done_o, wb_valid_o}, 32'd0);
    // directed corners
    run_op(32'h0000_1000, 16'h0000, 2'b00, 1, 0);
    run_op(32'h0000_1000, 16'h0000, 2'b11, 0, 0);
    for (int m = 0; m < 4; m++) run_op(32'h0000_2000, 16'hFFFF, 2'(m), 1, 0);
    for (int m = 0; m < 4; m++) run_op(32'h0000_0008, 16'h8421, 2'(m), 1, 0);
    run_op(32'h0000_0040, 16'h8000, 2'b11, 1, 0);
    run_op(32'h0000_0040, 16'h0001, 2'b01, 1, 0);
    run_op(32'h0000_0100, 16'h00F0, 2'b10, 1, 1);
    run_op(32'hFFFF_FFF8, 16'h0007, 2'b00, 1, 0);
    // random mix
    for (int t = 0; t < 60; t++) begin
      logic [15:0] l = 16'($urandom());
      if (t % 9 == 0) l = '0;
      run_op({$urandom()} & 32'hFFFF_FFFC, l, 2'($urandom()), 1'($urandom()), (t % 7) == 3);
    end
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule